// File: doc/BRIEF.md
# Two-Channel Vectored Interrupt Arbiter

This block collects interrupt requests from two peripherals and presents a single interrupt line to a processor. Each request only counts when its channel is unmasked, the block is globally enabled, and the channel is armed. An armed channel is one that has not yet been served for its current request level. When the processor answers with its take strobe, the arbiter picks one live channel, raises that channel's acknowledge, and presents the channel's programmed 8-bit vector index. The processor uses that index to look up the service routine in a 256-entry table. The acknowledge stays up until the processor drops the take strobe, which it does when the routine returns.

A tie between the two channels is settled either by fixed priority, where channel 0 always wins, or by rotating priority, where the channel served last yields. A four-register slave port holds the configuration: channel mask, one vector index per channel, and a control register. Every register reads back its stored byte one cycle after the read strobe.

Top module: `virq_arbiter`

## Requirements
- R1: After reset, all four registers read 0x00, `irq_out`, `irq_ack` and `vec_vld` are low, and the rotating pointer favours channel 0.
- R2: Register offsets are 0 for the mask, 1 for the channel 0 vector, 2 for the channel 1 vector and 3 for control. A write stores all 8 bits. A read returns the stored byte on `cfg_rdata` in the cycle after `cfg_rd`, and `cfg_rdata` holds that value until the next read.
- R3: `irq_out` is high exactly when some channel n is live. A channel n is live when `irq_req[n]` is high, mask bit n is set, control bit 0 (enable) is set, and the channel is armed.
- R4: If `irq_take` is high while no grant is active and a channel is live, exactly one bit of `irq_ack` rises in the next cycle, bit n for channel n. That bit stays high while `irq_take` stays high, and it is low in the cycle after `irq_take` is seen low.
- R5: With control bit 1 clear (fixed mode), channel 0 is granted when both channels are live.
- R6: With control bit 1 set (rotating mode), the channel granted most recently loses a tie with the other channel.
- R7: While an acknowledge is high, `vec_vld` is high and `vec_out` shows the granted channel's vector register. Otherwise `vec_vld` is low.
- R8: A granted channel is disarmed. It counts again only after its request has been seen low at a clock edge and then high again, so a request held high gets no second grant.
- R9: `irq_take` raised when no channel is live produces no acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 2 | Register offset |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data |
| irq_req | input | 2 | Peripheral request levels, bit n for channel n |
| irq_out | output | 1 | Combined interrupt to the processor |
| irq_take | input | 1 | Processor interrupt acknowledge, held high during service |
| irq_ack | output | 2 | Per-channel grant, at most one bit high |
| vec_out | output | 8 | Vector index of the granted channel |
| vec_vld | output | 1 | Vector output valid |

## Verification
The bench builds the block with its default vector width of 8. The channel count is fixed at two by the register map. With this build every register byte can be driven with distinct patterns, and the two vector values 13 and 17 identify which channel was granted. A sequence of re-arm steps drives the rotating pointer through both of its states, which shows the alternation between channels. Level-held requests show that a second grant is refused until the request falls and rises again.

// File: rtl/virq_pkg.sv
package virq_pkg;
  localparam int NCH      = 2;
  localparam int NREG     = 4;
  localparam int CTL_EN   = 0;
  localparam int CTL_ROT  = 1;

  typedef enum logic [1:0] {
    REG_MASK = 2'd0,
    REG_VEC0 = 2'd1,
    REG_VEC1 = 2'd2,
    REG_CTL  = 2'd3
  } reg_sel_e;

  typedef enum logic {
    HS_IDLE  = 1'b0,
    HS_GRANT = 1'b1
  } hs_state_e;
endpackage

// File: rtl/virq_regs.sv
module virq_regs
  import virq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_i,
  input  logic                          rd_i,
  input  logic [1:0]                    addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic [NCH-1:0]                mask_o,
  output logic [NCH-1:0][DATA_W-1:0]    vec_tab_o,
  output logic                          en_o,
  output logic                          rot_o
);
  logic [DATA_W-1:0] reg_q [NREG];
  logic [DATA_W-1:0] reg_d [NREG];
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    for (int i = 0; i < NREG; i++) reg_d[i] = reg_q[i];
    if (wr_i) reg_d[addr_i] = wdata_i;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_i) rdata_d = reg_q[addr_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) reg_q[i] <= '0;
      rdata_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) reg_q[i] <= reg_d[i];
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o      = rdata_q;
  assign mask_o       = reg_q[REG_MASK][NCH-1:0];
  assign vec_tab_o[0] = reg_q[REG_VEC0];
  assign vec_tab_o[1] = reg_q[REG_VEC1];
  assign en_o         = reg_q[REG_CTL][CTL_EN];
  assign rot_o        = reg_q[REG_CTL][CTL_ROT];

  p_rd_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == REG_MASK) |=> (rdata_o == $past(reg_q[REG_MASK])));
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/virq_qual.sv
module virq_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic allow_i,
  input  logic grant_i,
  output logic live_o
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    if (!req_i)       armed_d = 1'b1;
    else if (grant_i) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b1;
    else        armed_q <= armed_d;
  end

  assign live_o = req_i & armed_q & allow_i;

  p_no_regrant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_i |=> (!req_i || !live_o));
endmodule

// File: rtl/virq_hs.sv
module virq_hs
  import virq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        take_i,
  input  logic [NCH-1:0]              live_i,
  input  logic                        rot_i,
  input  logic [NCH-1:0][DATA_W-1:0]  vec_tab_i,
  output logic [NCH-1:0]              grant_o,
  output logic [NCH-1:0]              ack_o,
  output logic [DATA_W-1:0]           vec_o,
  output logic                        vld_o
);
  hs_state_e          state_q, state_d;
  logic [NCH-1:0]     ack_q, ack_d;
  logic [DATA_W-1:0]  vec_q, vec_d;
  logic               last_q, last_d;
  logic [NCH-1:0]     pick;

  // Tie-break: fixed favours channel 0; rotating favours the one not served last.
  always_comb begin
    pick = live_i;
    if (live_i == 2'b11) begin
      if (rot_i && !last_q) pick = 2'b10;
      else                  pick = 2'b01;
    end
  end

  always_comb begin
    state_d = state_q;
    ack_d   = ack_q;
    vec_d   = vec_q;
    last_d  = last_q;
    grant_o = '0;
    case (state_q)
      HS_IDLE: begin
        if (take_i && (|live_i)) begin
          state_d = HS_GRANT;
          grant_o = pick;
          ack_d   = pick;
          vec_d   = pick[1] ? vec_tab_i[1] : vec_tab_i[0];
          last_d  = pick[1];
        end
      end
      HS_GRANT: begin
        if (!take_i) begin
          state_d = HS_IDLE;
          ack_d   = '0;
        end
      end
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      ack_q   <= '0;
      vec_q   <= '0;
      last_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
      vec_q   <= vec_d;
      last_q  <= last_d;
    end
  end

  assign ack_o = ack_q;
  assign vec_o = vec_q;
  assign vld_o = (state_q == HS_GRANT);

  p_ack_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o));
  p_ack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ack_o) && !take_i) |=> (ack_o == '0));
  p_ack_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|ack_o) |-> $past(take_i && (|live_i)));
  p_fixed_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_IDLE && take_i && live_i == 2'b11 && !rot_i) |=> (ack_o == 2'b01));
  p_vld_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o == (|ack_o));
endmodule

// File: rtl/virq_arbiter.sv
module virq_arbiter
  import virq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [1:0]        irq_req,
  output logic              irq_out,
  input  logic              irq_take,
  output logic [1:0]        irq_ack,
  output logic [DATA_W-1:0] vec_out,
  output logic              vec_vld
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [NCH-1:0]             mask;
  logic [NCH-1:0][DATA_W-1:0] vec_tab;
  logic                       en, rot;
  logic [NCH-1:0]             live, grant;

  virq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n_int),
    .wr_i(cfg_wr), .rd_i(cfg_rd), .addr_i(cfg_addr), .wdata_i(cfg_wdata),
    .rdata_o(cfg_rdata), .mask_o(mask), .vec_tab_o(vec_tab),
    .en_o(en), .rot_o(rot)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    virq_qual u_qual (
      .clk(clk), .rst_n(rst_n_int),
      .req_i(irq_req[g]), .allow_i(mask[g] & en),
      .grant_i(grant[g]), .live_o(live[g])
    );
  end

  virq_hs #(.DATA_W(DATA_W)) u_hs (
    .clk(clk), .rst_n(rst_n_int),
    .take_i(irq_take), .live_i(live), .rot_i(rot), .vec_tab_i(vec_tab),
    .grant_o(grant), .ack_o(irq_ack), .vec_o(vec_out), .vld_o(vec_vld)
  );

  assign irq_out = |live;

  p_int_gate_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    !en |-> !irq_out);
  p_ack_requested_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(irq_ack[0]) |-> $past(irq_req[0]));
endmodule

// File: tb/sim_virq_arbiter.sv
`timescale 1ns/100ps
module sim_virq_arbiter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr, cfg_rd;
  logic [1:0] cfg_addr;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic [1:0] irq_req, irq_ack;
  logic       irq_out, irq_take, vec_vld;
  logic [7:0] vec_out;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  virq_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_req(irq_req), .irq_out(irq_out), .irq_take(irq_take),
    .irq_ack(irq_ack), .vec_out(vec_out), .vec_vld(vec_vld)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(logic [1:0] a, logic [7:0] exp, string tag);
    cfg_rd = 1'b1; cfg_addr = a;
    step();
    cfg_rd = 1'b0;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic rearm(logic [1:0] r);
    irq_req = 2'b00; step();
    irq_req = r;     step();
  endtask

  task automatic t_reset();
    chk("R1 irq_out", irq_out, 0);
    chk("R1 irq_ack", irq_ack, 0);
    chk("R1 vec_vld", vec_vld, 0);
    for (int i = 0; i < 4; i++) rd_chk(i[1:0], 8'h00, "R1 reg reset");
  endtask

  task automatic t_regs();
    wr_reg(2'd0, 8'hA5); wr_reg(2'd1, 8'h3C);
    wr_reg(2'd2, 8'hC3); wr_reg(2'd3, 8'hFC);
    rd_chk(2'd0, 8'hA5, "R2 mask");
    rd_chk(2'd1, 8'h3C, "R2 vec0");
    rd_chk(2'd2, 8'hC3, "R2 vec1");
    rd_chk(2'd3, 8'hFC, "R2 ctl");
    step();
    chk("R2 rdata hold", cfg_rdata, 8'hFC);
    wr_reg(2'd0, 8'h00); wr_reg(2'd1, 8'd13);
    wr_reg(2'd2, 8'd17); wr_reg(2'd3, 8'h00);
  endtask

  task automatic t_gate();
    irq_req = 2'b11; step();
    chk("R3 masked+disabled", irq_out, 0);
    wr_reg(2'd0, 8'h03);
    chk("R3 disabled", irq_out, 0);
    wr_reg(2'd3, 8'h01);
    chk("R3 enabled", irq_out, 1);
    wr_reg(2'd0, 8'h02); irq_req = 2'b01; step();
    chk("R3 ch0 masked", irq_out, 0);
    wr_reg(2'd0, 8'h03);
    chk("R3 ch0 unmasked", irq_out, 1);
  endtask

  task automatic t_fixed();
    irq_req = 2'b11; irq_take = 1'b1; step();
    chk("R5 fixed winner", irq_ack, 2'b01);
    chk("R7 vec ch0", vec_out, 8'd13);
    chk("R7 vld", vec_vld, 1);
    step();
    chk("R4 ack held", irq_ack, 2'b01);
    irq_take = 1'b0; step();
    chk("R4 ack dropped", irq_ack, 2'b00);
    chk("R7 vld low", vec_vld, 0);
  endtask

  task automatic t_rearm();
    chk("R8 ch1 still live", irq_out, 1);
    irq_take = 1'b1; step();
    chk("R4 ch1 granted", irq_ack, 2'b10);
    chk("R7 vec ch1", vec_out, 8'd17);
    irq_take = 1'b0; step();
    chk("R8 held reqs not live", irq_out, 0);
    irq_take = 1'b1; step();
    chk("R8 no second grant", irq_ack, 2'b00);
    irq_take = 1'b0;
    rearm(2'b11);
    chk("R8 rearmed", irq_out, 1);
  endtask

  task automatic t_rotate();
    wr_reg(2'd3, 8'h03);
    irq_take = 1'b1; step();
    chk("R6 ch1 last -> ch0", irq_ack, 2'b01);
    irq_take = 1'b0; step();
    rearm(2'b11);
    irq_take = 1'b1; step();
    chk("R6 ch0 last -> ch1", irq_ack, 2'b10);
    chk("R7 vec rot ch1", vec_out, 8'd17);
    irq_take = 1'b0; step();
    rearm(2'b11);
    irq_take = 1'b1; step();
    chk("R6 ch1 last -> ch0 again", irq_ack, 2'b01);
    irq_take = 1'b0; step();
  endtask

  task automatic t_none();
    irq_req = 2'b00; step();
    irq_take = 1'b1; step();
    chk("R9 no ack", irq_ack, 2'b00);
    chk("R9 no vld", vec_vld, 0);
    chk("R9 no int", irq_out, 0);
    irq_take = 1'b0; step();
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 0; cfg_rd = 0; cfg_addr = 0; cfg_wdata = 0;
    irq_req = 0; irq_take = 0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_regs();
    t_gate();
    t_fixed();
    t_rearm();
    t_rotate();
    t_none();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule